// File: doc/BRIEF.md
# Serial MII Receive Deframer

This block sits on the MAC side of a serial media-independent interface and turns the single receive line back into parallel information. A local sync pulse marks where each 10-bit segment starts. The block gathers the ten bits into a carrier flag, a data-valid flag and an 8-bit lane. While data-valid is set, the lane is a packet byte and is handed on with a one-cycle strobe. While data-valid is clear, the lane carries line status from the PHY, and the block holds that status in a register that drives seven status outputs.

In the fast mode every segment is a new byte. In the slow mode the far end sends each segment ten times. The block then keeps one copy of each group and drops the rest. Its copy counter is realigned on the first segment whose data-valid is set after a gap, so it accepts the first copy of every byte. A one-cycle frame-end pulse marks the first accepted non-data segment after a frame.

Top module: `serial_mii_rx`

## Requirements
- R1: A high `sync_i` marks the first bit of a segment. The bits of a segment arrive in this order: carrier, data-valid, then lane bits 0 to 7. The outputs show a segment's content in the second cycle after its tenth bit is sampled.
- R2: A segment that is cut short by a new `sync_i` before its tenth bit is discarded. It produces no byte and no status change.
- R3: Each accepted segment with data-valid 1 puts its lane on `byte_o` and raises `byte_vld_o` for exactly one cycle.
- R4: Each accepted segment with data-valid 0 loads the status outputs from its lane. The mapping is: bit 0 receive error, bit 1 speed (1 = 100 Mbit/s), bit 2 duplex (1 = full), bit 3 link (1 = up), bit 4 jabber, bit 5 last upper nibble valid, bit 6 false carrier. Lane bit 7 is ignored.
- R5: Segments with data-valid 1 leave the status outputs unchanged.
- R6: `frame_end_o` pulses for one cycle on the first accepted data-valid-0 segment that follows an accepted data-valid-1 segment.
- R7: With `mode_100_i` low, the first segment whose data-valid rises is accepted. After that, every tenth segment is accepted and the nine in between are ignored. A frame of N bytes sent as ten copies each yields exactly N bytes.
- R8: With `mode_100_i` low, status is taken only from accepted segments. Copies that fall between accepted segments do not change the status outputs.
- R9: `crs_o` and `dv_o` show the carrier and data-valid bits of the last accepted segment.
- R10: While `rst` is high, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, one bit per cycle |
| rst | input | 1 | Synchronous active-high reset |
| rxd_i | input | 1 | Serial receive line |
| sync_i | input | 1 | Segment start marker, high with the first bit |
| mode_100_i | input | 1 | 1 = every segment is new, 0 = tenfold repetition |
| crs_o | output | 1 | Carrier bit of last accepted segment |
| dv_o | output | 1 | Data-valid bit of last accepted segment |
| byte_o | output | 8 | Last received packet byte |
| byte_vld_o | output | 1 | One-cycle strobe for a new byte |
| frame_end_o | output | 1 | One-cycle pulse when a frame ends |
| st_rx_err_o | output | 1 | Receive error in previous frame |
| st_speed_o | output | 1 | Line speed, 1 = 100 Mbit/s |
| st_duplex_o | output | 1 | Duplex, 1 = full |
| st_link_o | output | 1 | Link up |
| st_jabber_o | output | 1 | Jabber detected |
| st_nibble_ok_o | output | 1 | Upper nibble of last byte valid |
| st_false_carrier_o | output | 1 | False carrier detected |

## Verification
The hardest case to reach is a status change landing on one of the nine ignored copies in slow mode. Showing that it is ignored needs the copy counter's phase to be known, and the bench cannot read that phase. The stimulus sets the phase through the realignment rule. It sends a few idle segments at an unknown phase, then a frame whose first data segment fixes the phase. It then sends one status segment followed by nine different ones. The status outputs are checked just as the next accepted segment is about to land. The cut-short segment is reached by raising sync after only five bits.

// File: rtl/srx_pkg.sv
package srx_pkg;
  localparam int BYTE_W = 8;
  localparam int SEG_W  = BYTE_W + 2;
  localparam int ST_W   = 7;

  typedef struct packed {
    logic [BYTE_W-1:0] lane;
    logic              dv;
    logic              crs;
  } seg_t;

  typedef struct packed {
    logic false_carrier;
    logic nibble_ok;
    logic jabber;
    logic link;
    logic duplex;
    logic speed;
    logic rx_err;
  } status_t;
endpackage

// File: rtl/srx_seg_capture.sv
module srx_seg_capture
  import srx_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic rxd_i,
  input  logic sync_i,
  output seg_t seg_o,
  output logic seg_vld_o
);
  localparam int CW = $clog2(SEG_W + 1);

  logic [SEG_W-2:0] sh;
  logic [CW-1:0]    pos;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh        <= '0;
      pos       <= CW'(SEG_W);
      seg_o     <= '0;
      seg_vld_o <= 1'b0;
    end else begin
      sh        <= {rxd_i, sh[SEG_W-2:1]};
      seg_vld_o <= 1'b0;
      if (sync_i) begin
        pos <= CW'(1);
      end else if (pos == CW'(SEG_W - 1)) begin
        seg_o     <= seg_t'({rxd_i, sh});
        seg_vld_o <= 1'b1;
        pos       <= CW'(SEG_W);
      end else if (pos < CW'(SEG_W)) begin
        pos <= pos + CW'(1);
      end
    end
  end
endmodule

// File: rtl/srx_rate_gate.sv
module srx_rate_gate #(
  parameter int REPEAT = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic mode_100_i,
  input  logic seg_vld_i,
  input  logic dv_i,
  output logic take_o
);
  localparam int RW = $clog2(REPEAT);

  logic [RW-1:0] ph;
  logic          last_dv;
  logic          rise;

  always_comb begin
    rise   = dv_i && !last_dv;
    take_o = seg_vld_i && (mode_100_i || rise || (ph == '0));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph      <= '0;
      last_dv <= 1'b0;
    end else if (seg_vld_i) begin
      last_dv <= dv_i;
      if (rise)                      ph <= RW'(1);
      else if (ph == RW'(REPEAT-1))  ph <= '0;
      else                           ph <= ph + RW'(1);
    end
  end
endmodule

// File: rtl/srx_lane_sort.sv
module srx_lane_sort
  import srx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              take_i,
  input  seg_t              seg_i,
  output logic              crs_o,
  output logic              dv_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic              byte_vld_o,
  output logic              frame_end_o,
  output status_t           status_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      crs_o       <= 1'b0;
      dv_o        <= 1'b0;
      byte_o      <= '0;
      byte_vld_o  <= 1'b0;
      frame_end_o <= 1'b0;
      status_o    <= '0;
    end else begin
      byte_vld_o  <= 1'b0;
      frame_end_o <= 1'b0;
      if (take_i) begin
        crs_o <= seg_i.crs;
        dv_o  <= seg_i.dv;
        if (seg_i.dv) begin
          byte_o     <= seg_i.lane;
          byte_vld_o <= 1'b1;
        end else begin
          status_o    <= status_t'(seg_i.lane[ST_W-1:0]);
          frame_end_o <= dv_o;
        end
      end
    end
  end
endmodule

// File: rtl/serial_mii_rx.sv
module serial_mii_rx
  import srx_pkg::*;
#(
  parameter int REPEAT = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rxd_i,
  input  logic              sync_i,
  input  logic              mode_100_i,
  output logic              crs_o,
  output logic              dv_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic              byte_vld_o,
  output logic              frame_end_o,
  output logic              st_rx_err_o,
  output logic              st_speed_o,
  output logic              st_duplex_o,
  output logic              st_link_o,
  output logic              st_jabber_o,
  output logic              st_nibble_ok_o,
  output logic              st_false_carrier_o
);
  seg_t    seg;
  logic    seg_vld;
  logic    take;
  status_t status;

  srx_seg_capture u_cap (
    .clk(clk), .rst(rst), .rxd_i(rxd_i), .sync_i(sync_i),
    .seg_o(seg), .seg_vld_o(seg_vld)
  );

  srx_rate_gate #(.REPEAT(REPEAT)) u_gate (
    .clk(clk), .rst(rst), .mode_100_i(mode_100_i),
    .seg_vld_i(seg_vld), .dv_i(seg.dv), .take_o(take)
  );

  srx_lane_sort u_sort (
    .clk(clk), .rst(rst), .take_i(take), .seg_i(seg),
    .crs_o(crs_o), .dv_o(dv_o), .byte_o(byte_o),
    .byte_vld_o(byte_vld_o), .frame_end_o(frame_end_o),
    .status_o(status)
  );

  assign st_rx_err_o        = status.rx_err;
  assign st_speed_o         = status.speed;
  assign st_duplex_o        = status.duplex;
  assign st_link_o          = status.link;
  assign st_jabber_o        = status.jabber;
  assign st_nibble_ok_o     = status.nibble_ok;
  assign st_false_carrier_o = status.false_carrier;
endmodule

// File: rtl/serial_mii_rx_chk.sv
module serial_mii_rx_chk #(
  parameter int SEG_W = 10,
  parameter int ST_W  = 7
) (
  input logic            clk,
  input logic            rst,
  input logic            byte_vld_o,
  input logic            frame_end_o,
  input logic            dv_o,
  input logic [ST_W-1:0] st_i
);
  localparam int GW = $clog2(SEG_W + 1);
  logic [GW-1:0] since;

  always_ff @(posedge clk) begin
    if (rst)                       since <= GW'(SEG_W);
    else if (byte_vld_o)           since <= '0;
    else if (since < GW'(SEG_W))   since <= since + GW'(1);
  end

  // R3
  byte_gap_chk: assert property (@(posedge clk) disable iff (rst)
    byte_vld_o |-> (since >= GW'(SEG_W - 1)));

  // R3
  pulse_once_chk: assert property (@(posedge clk) disable iff (rst)
    byte_vld_o |=> !byte_vld_o);

  // R6
  frame_end_chk: assert property (@(posedge clk) disable iff (rst)
    frame_end_o |-> (!dv_o && $past(dv_o)));

  // R5
  status_hold_chk: assert property (@(posedge clk) disable iff (rst)
    dv_o |-> $stable(st_i));
endmodule

bind serial_mii_rx serial_mii_rx_chk #(.SEG_W(srx_pkg::SEG_W), .ST_W(srx_pkg::ST_W)) u_chk (
  .clk(clk), .rst(rst), .byte_vld_o(byte_vld_o), .frame_end_o(frame_end_o),
  .dv_o(dv_o),
  .st_i({st_false_carrier_o, st_nibble_ok_o, st_jabber_o, st_link_o,
         st_duplex_o, st_speed_o, st_rx_err_o})
);

// File: tb/serial_mii_rx_bench.sv
`timescale 1ns/1ps
module serial_mii_rx_bench;
  logic clk = 1'b0, rst = 1'b1, rxd = 1'b0, sync = 1'b0, mode_100 = 1'b1;
  logic crs_o, dv_o, byte_vld_o, frame_end_o;
  logic [7:0] byte_o;
  logic st_err, st_spd, st_dup, st_lnk, st_jab, st_nib, st_fc;
  logic [6:0] st_now;

  always #4 clk = ~clk;

  serial_mii_rx u_serial_mii_rx (
    .clk(clk), .rst(rst), .rxd_i(rxd), .sync_i(sync), .mode_100_i(mode_100),
    .crs_o(crs_o), .dv_o(dv_o), .byte_o(byte_o), .byte_vld_o(byte_vld_o),
    .frame_end_o(frame_end_o), .st_rx_err_o(st_err), .st_speed_o(st_spd),
    .st_duplex_o(st_dup), .st_link_o(st_lnk), .st_jabber_o(st_jab),
    .st_nibble_ok_o(st_nib), .st_false_carrier_o(st_fc)
  );

  assign st_now = {st_fc, st_nib, st_jab, st_lnk, st_dup, st_spd, st_err};

  int checks = 0, fails = 0;
  int nget = 0, nfe = 0;
  logic [7:0] got [0:31];
  logic s_vld, s_fe, s_crs, s_dv;
  logic [7:0] s_byte;
  logic [6:0] s_st;

  always @(negedge clk) begin
    if (!rst) begin
      if (byte_vld_o) begin
        if (nget < 32) got[nget] = byte_o;
        nget++;
      end
      if (frame_end_o) nfe++;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Drives one segment; at its second bit it snapshots the outputs,
  // which by then show the result of the previous segment (R1 latency).
  task automatic send_seg(input logic c, input logic v, input logic [7:0] d);
    logic [9:0] bits;
    bits = {d, v, c};
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      sync = (k == 0);
      rxd  = bits[k];
      if (k == 1) begin
        s_vld = byte_vld_o; s_fe = frame_end_o; s_byte = byte_o;
        s_st = st_now; s_crs = crs_o; s_dv = dv_o;
      end
    end
  endtask

  // {crs, dv, lane, expected frame end, expected status}
  localparam logic [17:0] VEC [0:9] = '{
    {1'b0, 1'b0, 8'h0E, 1'b0, 7'h0E},
    {1'b1, 1'b0, 8'h0E, 1'b0, 7'h0E},
    {1'b1, 1'b1, 8'h55, 1'b0, 7'h0E},
    {1'b1, 1'b1, 8'hD5, 1'b0, 7'h0E},
    {1'b1, 1'b1, 8'h3C, 1'b0, 7'h0E},
    {1'b0, 1'b0, 8'h2F, 1'b1, 7'h2F},
    {1'b0, 1'b0, 8'h2F, 1'b0, 7'h2F},
    {1'b0, 1'b0, 8'hCA, 1'b0, 7'h4A},
    {1'b1, 1'b1, 8'hA7, 1'b0, 7'h4A},
    {1'b0, 1'b0, 8'h9E, 1'b1, 7'h1E}
  };

  task automatic check_vec(input logic [17:0] v);
    chk("R1 R9 crs_o", int'(s_crs), int'(v[17]));
    chk("R9 dv_o", int'(s_dv), int'(v[16]));
    chk("R3 byte_vld_o", int'(s_vld), int'(v[16]));
    if (v[16]) chk("R3 byte_o", int'(s_byte), int'(v[15:8]));
    chk("R6 frame_end_o", int'(s_fe), int'(v[7]));
    chk("R4 R5 status", int'(s_st), int'(v[6:0]));
  endtask

  initial begin
    int n0, f0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 reset outputs", int'({crs_o, dv_o, byte_o, byte_vld_o, frame_end_o, st_now}), 0);
    @(negedge clk); rst = 1'b0;

    for (int i = 0; i < 10; i++) begin
      send_seg(VEC[i][17], VEC[i][16], VEC[i][15:8]);
      if (i > 0) check_vec(VEC[i-1]);
    end
    send_seg(1'b0, 1'b0, 8'h1E);
    check_vec(VEC[9]);

    // R2: segment cut short by an early sync is discarded
    n0 = nget; f0 = nfe;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk); sync = (k == 0); rxd = 1'b1;
    end
    send_seg(1'b1, 1'b1, 8'h66);
    send_seg(1'b0, 1'b0, 8'h0E);
    send_seg(1'b0, 1'b0, 8'h0E);
    chk("R2 bytes after partial", nget - n0, 1);
    chk("R2 byte value", int'(got[n0]), 8'h66);
    chk("R2 R6 frame ends", nfe - f0, 1);

    // R7 / R8: tenfold repetition mode
    @(negedge clk); mode_100 = 1'b0;
    for (int k = 0; k < 3; k++) send_seg(1'b0, 1'b0, 8'h0E);
    n0 = nget; f0 = nfe;
    for (int k = 0; k < 10; k++) send_seg(1'b1, 1'b1, 8'h11);
    for (int k = 0; k < 10; k++) send_seg(1'b1, 1'b1, 8'h22);
    send_seg(1'b0, 1'b0, 8'h0C);
    for (int k = 0; k < 9; k++) send_seg(1'b0, 1'b0, 8'h4F);
    send_seg(1'b0, 1'b0, 8'h0C);
    chk("R8 status ignores repeats", int'(s_st), 7'h0C);
    chk("R7 dv_o after frame", int'(s_dv), 0);
    send_seg(1'b0, 1'b0, 8'h0C);
    chk("R7 byte count", nget - n0, 2);
    chk("R7 first byte", int'(got[n0]), 8'h11);
    chk("R7 second byte", int'(got[n0+1]), 8'h22);
    chk("R7 R6 frame end count", nfe - f0, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule